// File: doc/BRIEF.md
# Confidence-Filtered Cross-Core Translation Push

After a core misses in both its translation lookaside buffer and its prefetch buffer, it walks the page table. This block then decides which other cores get a copy of the new translation. It keeps one 2-bit saturating confidence counter for each peer core. One cycle after the walk miss is reported, it produces a target bitmask that names only the peers whose counter shows confidence. The message network that delivers the translation and the per-core prefetch buffers sit outside the block.

The counters learn from messages that arrive from the peers:

- A peer that later uses a pushed entry sends a hit notice, which raises that peer's counter.
- A peer that discards a pushed entry without using it sends an eviction notice, which lowers that peer's counter.
- A peer that itself suffers a walk miss broadcasts a miss notice, which also raises that peer's counter.

Together these let the push set follow the sharing pattern of the running workload instead of always sending to every core.

Top module: `lf_prefetch_filter`

## Requirements
- R1: While reset is high and in the first cycle after it, `fwd_valid` is 0 and `fwd_mask` is all zeros. Every counter leaves reset at 3, so the first push goes to every core except this one.
- R2: If `walk_miss` is high in cycle t, then `fwd_valid` is 1 in cycle t+1 and bit j of `fwd_mask` is 1 exactly when peer j's counter was 2 or 3 at the start of cycle t. Counter changes made in cycle t do not affect this mask. If `walk_miss` is low in cycle t, then in cycle t+1 `fwd_valid` is 0 and `fwd_mask` is all zeros.
- R3: Bit `self_id` of `fwd_mask` is never 1.
- R4: A hit notice (`peer_hit_valid`, id in `peer_hit_id`) raises counter `peer_hit_id` by one.
- R5: An eviction notice (`peer_evict_valid`, id in `peer_evict_id`) lowers counter `peer_evict_id` by one. No other event lowers a counter.
- R6: A miss notice (`peer_miss_valid`, id in `peer_miss_id`) raises counter `peer_miss_id` by one.
- R7: A counter at 3 stays at 3 when raised. A counter at 0 stays at 0 when lowered.
- R8: When a raise and a lower reach the same counter in the same cycle, the counter keeps its value. A hit notice and a miss notice for the same counter in one cycle raise it by one step only.
- R9: A notice that names `self_id`, or an id of `NUM_CORES` or more, changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| self_id | input | ID_W | Index of the core that owns this block (held static) |
| walk_miss | input | 1 | Miss in both the TLB and the prefetch buffer; a translation is ready to push |
| peer_hit_valid | input | 1 | A peer hit on an entry that this core pushed |
| peer_hit_id | input | ID_W | Peer that sent the hit notice |
| peer_evict_valid | input | 1 | A peer evicted an entry pushed by this core without using it |
| peer_evict_id | input | ID_W | Peer that sent the eviction notice |
| peer_miss_valid | input | 1 | A peer broadcast its own walk miss |
| peer_miss_id | input | ID_W | Peer that missed |
| fwd_valid | output | 1 | Push decision present this cycle |
| fwd_mask | output | NUM_CORES | Bit j set: send the translation to core j |

## Verification
A counter that sits at the wrong value is hidden while it stays on the same side of the threshold. It becomes visible on the first walk miss after it crosses the boundary between 1 and 2: the next cycle's `fwd_mask` then shows the wrong bit. For this reason the stimulus drives each counter through both saturation limits and across the threshold, with a miss pushed in every step. An error in saturation, cancellation or id filtering therefore shows one cycle after the step that causes it. The bench also mixes in random notice traffic and compares against a behavioural model every cycle.

// File: rtl/lf_pkg.sv
package lf_pkg;

    localparam int CONF_W      = 2;
    localparam int CONF_MAX    = (1 << CONF_W) - 1;
    localparam int CONF_THRESH = 2;
    localparam int CONF_INIT   = CONF_MAX;

    typedef logic [CONF_W-1:0] conf_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    function automatic step_e resolve_step(input logic up, input logic down);
        if (up && !down) return STEP_UP;
        if (down && !up) return STEP_DOWN;
        return STEP_HOLD;
    endfunction

    function automatic conf_t apply_step(input conf_t cur, input step_e st);
        conf_t nxt;
        nxt = cur;
        if (st == STEP_UP && cur != conf_t'(CONF_MAX)) nxt = cur + conf_t'(1);
        else if (st == STEP_DOWN && cur != conf_t'(0)) nxt = cur - conf_t'(1);
        return nxt;
    endfunction

    function automatic logic is_confident(input conf_t c);
        return c >= conf_t'(CONF_THRESH);
    endfunction

endpackage

// File: rtl/lf_msg_decode.sv
module lf_msg_decode
    import lf_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int ID_W      = 3
) (
    input  logic [ID_W-1:0] self_id,
    input  logic            hit_v,
    input  logic [ID_W-1:0] hit_id,
    input  logic            evict_v,
    input  logic [ID_W-1:0] evict_id,
    input  logic            miss_v,
    input  logic [ID_W-1:0] miss_id,
    output step_e           steps [NUM_CORES]
);

    for (genvar j = 0; j < NUM_CORES; j++) begin : g_dec
        logic not_self;
        logic up;
        logic down;
        always_comb begin
            not_self = (int'(self_id) != j);
            up       = not_self && ((hit_v && int'(hit_id) == j) ||
                                    (miss_v && int'(miss_id) == j));
            down     = not_self && evict_v && int'(evict_id) == j;
            steps[j] = resolve_step(up, down);
        end
    end

endmodule

// File: rtl/lf_conf_ctr.sv
module lf_conf_ctr
    import lf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  step_e step,
    output conf_t level
);

    always_ff @(posedge clk) begin
        if (rst) level <= conf_t'(CONF_INIT);
        else     level <= apply_step(level, step);
    end

endmodule

// File: rtl/lf_target_select.sv
module lf_target_select
    import lf_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int ID_W      = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ID_W-1:0]      self_id,
    input  logic                 trigger,
    input  conf_t                levels [NUM_CORES],
    output logic                 out_valid,
    output logic [NUM_CORES-1:0] out_mask
);

    logic [NUM_CORES-1:0] pick;

    for (genvar j = 0; j < NUM_CORES; j++) begin : g_pick
        assign pick[j] = is_confident(levels[j]) && (int'(self_id) != j);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_mask  <= '0;
        end else begin
            out_valid <= trigger;
            out_mask  <= trigger ? pick : '0;
        end
    end

endmodule

// File: rtl/lf_prefetch_filter.sv
module lf_prefetch_filter
    import lf_pkg::*;
#(
    parameter  int NUM_CORES = 8,
    localparam int ID_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ID_W-1:0]      self_id,
    input  logic                 walk_miss,
    input  logic                 peer_hit_valid,
    input  logic [ID_W-1:0]      peer_hit_id,
    input  logic                 peer_evict_valid,
    input  logic [ID_W-1:0]      peer_evict_id,
    input  logic                 peer_miss_valid,
    input  logic [ID_W-1:0]      peer_miss_id,
    output logic                 fwd_valid,
    output logic [NUM_CORES-1:0] fwd_mask
);

    step_e steps  [NUM_CORES];
    conf_t levels [NUM_CORES];

    lf_msg_decode #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) u_dec (
        .self_id  (self_id),
        .hit_v    (peer_hit_valid),
        .hit_id   (peer_hit_id),
        .evict_v  (peer_evict_valid),
        .evict_id (peer_evict_id),
        .miss_v   (peer_miss_valid),
        .miss_id  (peer_miss_id),
        .steps    (steps)
    );

    for (genvar j = 0; j < NUM_CORES; j++) begin : g_ctr
        lf_conf_ctr u_ctr (
            .clk   (clk),
            .rst   (rst),
            .step  (steps[j]),
            .level (levels[j])
        );
    end

    lf_target_select #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .self_id   (self_id),
        .trigger   (walk_miss),
        .levels    (levels),
        .out_valid (fwd_valid),
        .out_mask  (fwd_mask)
    );

endmodule

// File: rtl/lf_prefetch_filter_chk.sv
module lf_prefetch_filter_chk #(
    parameter  int NUM_CORES = 8,
    localparam int ID_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ID_W-1:0]      self_id,
    input logic                 walk_miss,
    input logic                 peer_hit_valid,
    input logic [ID_W-1:0]      peer_hit_id,
    input logic                 peer_evict_valid,
    input logic [ID_W-1:0]      peer_evict_id,
    input logic                 peer_miss_valid,
    input logic [ID_W-1:0]      peer_miss_id,
    input logic                 fwd_valid,
    input logic [NUM_CORES-1:0] fwd_mask
);

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_IDLE_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
        !fwd_valid |-> fwd_mask == '0); // R2
    AST_ISSUE_AFTER_MISS: assert property (@(posedge clk) disable iff (rst)
        walk_miss |=> fwd_valid); // R2
    AST_NO_SPURIOUS_ISSUE: assert property (@(posedge clk) disable iff (rst)
        !walk_miss |=> !fwd_valid); // R2
    AST_SELF_EXCLUDED: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> !fwd_mask[self_id]); // R3

    for (genvar j = 0; j < NUM_CORES; j++) begin : g_keep
        AST_ONLY_EVICT_LOWERS: assert property (@(posedge clk) disable iff (rst)
            (since_rst == 2'd3 && fwd_valid && $past(fwd_valid) && $past(fwd_mask[j])
             && !($past(peer_evict_valid, 2) && int'($past(peer_evict_id, 2)) == j))
            |-> fwd_mask[j]); // R5
    end

endmodule

bind lf_prefetch_filter lf_prefetch_filter_chk #(.NUM_CORES(NUM_CORES)) u_chk (.*);

// File: tb/lf_prefetch_filter_tb.sv
module lf_prefetch_filter_tb;

    localparam int N    = 8;
    localparam int IDW  = 3;
    localparam int SELF = 2;

    logic           clk = 1'b0;
    logic           rst;
    logic [IDW-1:0] self_id;
    logic           walk_miss;
    logic           hv, ev, mv;
    logic [IDW-1:0] hid, eid, mid;
    logic           fwd_valid;
    logic [N-1:0]   fwd_mask;

    int checks = 0;
    int errors = 0;
    int conf [N];
    bit done = 0;

    always #2 clk = ~clk;

    lf_prefetch_filter #(.NUM_CORES(N)) u_dut (
        .clk(clk), .rst(rst), .self_id(self_id), .walk_miss(walk_miss),
        .peer_hit_valid(hv), .peer_hit_id(hid),
        .peer_evict_valid(ev), .peer_evict_id(eid),
        .peer_miss_valid(mv), .peer_miss_id(mid),
        .fwd_valid(fwd_valid), .fwd_mask(fwd_mask)
    );

    task automatic check(input string tag, input logic [N:0] act, input logic [N:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit m,
                        input bit h, input int hs, input bit e, input int es,
                        input bit r, input int rs);
        logic [N-1:0] exp_mask;
        @(negedge clk);
        walk_miss = m;
        hv = h; hid = IDW'(hs);
        ev = e; eid = IDW'(es);
        mv = r; mid = IDW'(rs);
        exp_mask = '0;
        if (m) for (int j = 0; j < N; j++) exp_mask[j] = (conf[j] >= 2) && (j != SELF);
        for (int j = 0; j < N; j++) begin
            bit up, dn;
            up = (h && hs == j) || (r && rs == j);
            dn = e && es == j;
            if (j != SELF) begin
                if (up && !dn && conf[j] < 3) conf[j]++;
                if (dn && !up && conf[j] > 0) conf[j]--;
            end
        end
        @(posedge clk);
        #1;
        check(tag, {fwd_valid, fwd_mask}, {m, exp_mask});
    endtask

    initial begin
        #300000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int j = 0; j < N; j++) conf[j] = 3;
        self_id = IDW'(SELF);
        rst = 1'b1; walk_miss = 0; hv = 0; ev = 0; mv = 0;
        hid = '0; eid = '0; mid = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 during reset", {fwd_valid, fwd_mask}, '0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R1 after reset", {fwd_valid, fwd_mask}, '0);
        step("R1 R3 first broadcast", 1, 0,0, 0,0, 0,0);
        step("R2 idle", 0, 0,0, 0,0, 0,0);
        // R5: core 5 from 3 down to 0, mask each step
        for (int k = 0; k < 5; k++) step("R5 evict lowers", 1, 0,0, 1,5, 0,0);
        step("R7 floor at zero", 1, 0,0, 0,0, 0,0);
        step("R4 hit raises", 1, 1,5, 0,0, 0,0);
        step("R6 miss notice raises", 1, 0,0, 0,0, 1,5);
        step("R4 R6 crossed threshold", 1, 0,0, 0,0, 0,0);
        // R7 ceiling: raise core 0 many times, then two evictions cross
        for (int k = 0; k < 4; k++) step("R7 ceiling", 1, 1,0, 0,0, 1,0);
        step("R7 one evict from ceiling", 1, 0,0, 1,0, 0,0);
        step("R7 second evict", 1, 0,0, 1,0, 0,0);
        step("R7 below threshold", 1, 0,0, 0,0, 0,0);
        // R8 cancel at boundary: core 1 to 2, then hit+evict together
        step("R8 prep", 1, 0,0, 1,1, 0,0);
        for (int k = 0; k < 3; k++) step("R8 cancel", 1, 1,1, 1,1, 0,0);
        step("R8 after cancel", 1, 0,0, 1,1, 0,0);
        step("R8 double raise one step", 1, 1,1, 0,0, 1,1);
        step("R8 evict after double", 1, 0,0, 1,1, 0,0);
        step("R8 check", 1, 0,0, 0,0, 0,0);
        // R9: self-named notices touch nothing
        for (int k = 0; k < 4; k++) step("R9 self notice", 1, 0,0, 1,SELF, 0,0);
        step("R9 self raise", 1, 1,SELF, 0,0, 1,SELF);
        step("R3 R9 result", 1, 0,0, 0,0, 0,0);
        // R2: miss concurrent with updates uses pre-update values
        step("R2 pre-update mask", 1, 0,0, 1,7, 0,0);
        step("R2 pre-update mask", 1, 0,0, 1,7, 0,0);
        step("R2 after", 1, 0,0, 0,0, 0,0);
        // mixed random traffic
        for (int k = 0; k < 400; k++)
            step("R2 R4 R5 R6 R7 R8 random", bit'($urandom_range(0,1)),
                 bit'($urandom_range(0,1)), $urandom_range(0,N-1),
                 bit'($urandom_range(0,1)), $urandom_range(0,N-1),
                 bit'($urandom_range(0,1)), $urandom_range(0,N-1));
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule